// File: doc/BRIEF.md
# Descriptor-Chained XOR and Fill DMA Engine

This single-channel engine follows a linked list of descriptors held in memory. Each descriptor asks for a plain copy, a constant fill, or an XOR of one to sixteen source buffers into a destination. A parity-check variant XORs the sources without storing the result. Instead, it records in the descriptor's byte-count word whether any result word was non-zero. Software points the engine at the first descriptor through a small register interface. It can link further descriptors onto the tail and ask the engine to pick them up. It reads busy, completion and error flags back from the status register.

All memory traffic goes through one word-wide master port with a request/grant handshake. The request and address stay steady until grant. Read data and the error response belong to the cycle of grant. Descriptor fields that control upper address bits, transfer direction and other bus attributes are read but have no effect.

Top module: `xdma_engine`

## Requirements
- R1: After reset the status register (byte offset 0x04) reads 0, the interrupt output is low and no memory request is made.
- R2: Software starts a chain by doing two things: it writes the first descriptor address to the next-descriptor register (0x24), then it writes 1 to the control register (0x00, bit 0 enable, bit 1 append) while enable was 0. A descriptor with source count 1 then copies its byte count from source 0 to the destination. The descriptor layout is: word 0 link, word 1 control, word 2 fill value, word 3 byte count in bits 23:0, word 4 destination, word 5 upper destination (ignored), and source i address at word 6+2i.
- R3: The descriptor control word is decoded as follows: bit 0 interrupt enable, bits 2:1 direction (ignored), bits 6:3 source count minus one, bit 7 zero-check, bit 8 fill and bit 11 write-back. In XOR mode each destination word is the bitwise XOR of the matching word of every source, for any count up to 16.
- R4: In fill mode every destination word within the byte count receives the descriptor's fill value, and the word after the buffer is left untouched.
- R5: In zero-check mode no destination word is written. With write-back enabled, word 3 is written back as the byte count, with bit 31 set and bit 30 set only if some XOR word was non-zero.
- R6: A descriptor with byte count 0 moves no data but still completes and sets end-of-transfer.
- R7: A link word of 0 ends the chain. The engine then sets end-of-chain (status bit 11), and busy (status bit 13) drops. A non-zero link is followed to the next descriptor.
- R8: Suppose the engine is idle with enable set and software then writes 0x3 to the control register. The engine re-reads the link word of the current descriptor and, if that word is non-zero, runs the descriptor it points to.
- R9: An error response on any memory access sets status bit 3, clears the enable bit, drops busy and leaves the current-descriptor register (0x08) unchanged.
- R10: Suppose a descriptor with interrupt enable completes. The interrupt output then stays high while end-of-transfer (bit 12) or end-of-chain (bit 11) is set. It also stays high while the error flag is set, whatever the interrupt enable bits. Status flags clear by writing 1 to them. Without interrupt enable, completion leaves the interrupt low.
- R11: The current-descriptor register reads the address of the descriptor that was last fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| mem_err | input | 1 | Error response, valid with grant |

## Verification
The hardest case to reach is the append path. The engine must already have finished a chain and raised end-of-chain. Only then is the tail link patched in memory and the append request issued, so the engine picks up work it never saw at start. The bench runs a one-descriptor chain to completion, rewrites that descriptor's link word through the memory model, and writes 0x3 to the control register. It also uses a source address outside the memory model to force an error response in the middle of a descriptor. The memory model withholds grant in a repeating pattern, so requests are held across stalls during fetch, read and write.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int BC_W    = 24;
    localparam int SRC_FW  = 4;
    localparam int MAX_SRC = 1 << SRC_FW;

    localparam logic [5:0] OFS_CTRL = 6'h00;
    localparam logic [5:0] OFS_STAT = 6'h04;
    localparam logic [5:0] OFS_CUR  = 6'h08;
    localparam logic [5:0] OFS_NEXT = 6'h24;

    localparam int BIT_BUSY = 13;
    localparam int BIT_EOT  = 12;
    localparam int BIT_EOC  = 11;
    localparam int BIT_ERR  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_RD, ST_WR, ST_WB, ST_DONE, ST_LINK
    } xdma_state_e;

    typedef struct packed {
        logic              irq_en;
        logic [SRC_FW-1:0] nsrc_m1;
        logic              zchk;
        logic              fill;
        logic              wback;
    } desc_ctl_t;
endpackage

// File: rtl/xdma_regs.sv
module xdma_regs
    import xdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cur_desc,
    input  logic              set_eot,
    input  logic              set_eoc,
    input  logic              set_err,
    input  logic              arm_irq,
    output logic              start,
    output logic              append,
    output logic [ADDR_W-1:0] start_addr,
    output logic              irq
);
    logic en_q, eot_q, eoc_q, err_q, arm_q;
    logic eot_n, eoc_n, err_n;
    logic [ADDR_W-1:0] next_q;
    logic wr_ctrl, wr_stat;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign start   = wr_ctrl && reg_wdata[0] && !reg_wdata[1] && !en_q && !busy;
    assign append  = wr_ctrl && reg_wdata[0] && reg_wdata[1] && !busy;
    assign start_addr = next_q;

    always_comb begin
        eot_n = set_eot || (eot_q && !(wr_stat && reg_wdata[BIT_EOT]));
        eoc_n = set_eoc || (eoc_q && !(wr_stat && reg_wdata[BIT_EOC]));
        err_n = set_err || (err_q && !(wr_stat && reg_wdata[BIT_ERR]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            eot_q  <= 1'b0;
            eoc_q  <= 1'b0;
            err_q  <= 1'b0;
            arm_q  <= 1'b0;
            next_q <= '0;
        end else begin
            if (set_err)      en_q <= 1'b0;
            else if (wr_ctrl) en_q <= reg_wdata[0];
            if (reg_wr && reg_addr == OFS_NEXT) next_q <= reg_wdata;
            eot_q <= eot_n;
            eoc_q <= eoc_n;
            err_q <= err_n;
            arm_q <= arm_irq || ((eot_n || eoc_n) && arm_q);
        end
    end

    assign irq = (arm_q && (eot_q || eoc_q)) || err_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata[0] = en_q;
            OFS_STAT: begin
                reg_rdata[BIT_BUSY] = busy;
                reg_rdata[BIT_EOT]  = eot_q;
                reg_rdata[BIT_EOC]  = eoc_q;
                reg_rdata[BIT_ERR]  = err_q;
            end
            OFS_CUR:  reg_rdata = cur_desc;
            OFS_NEXT: reg_rdata = next_q;
            default:  reg_rdata = '0;
        endcase
    end

    assert_err_disables_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> !en_q);

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[BIT_EOT] && reg_wdata[BIT_EOC] && reg_wdata[BIT_ERR]
         && !set_eot && !set_eoc && !set_err && !arm_irq) |=> !irq);
endmodule

// File: rtl/xdma_core.sv
module xdma_core
    import xdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              append,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              set_eot,
    output logic              set_eoc,
    output logic              set_err,
    output logic              arm_irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err
);
    localparam int WC_W = BC_W - 2;
    localparam int IW   = SRC_FW;

    xdma_state_e       state_q;
    logic [ADDR_W-1:0] cur_q, dest_q;
    desc_ctl_t         ctl_q;
    logic [DATA_W-1:0] fill_q, acc_q, acc_n;
    logic [BC_W-1:0]   bc_q;
    logic [ADDR_W-1:0] src_q [MAX_SRC];
    logic [5:0]        step_q;
    logic [IW-1:0]     sidx_q;
    logic [WC_W-1:0]   widx_q, nwords;
    logic              zr_q;
    logic              xfer, ok, last_src, last_word, last_fetch;
    logic [IW:0]       nsrc;
    xdma_state_e       post_st, first_st;

    assign nsrc       = {1'b0, ctl_q.nsrc_m1} + 1'b1;
    assign nwords     = bc_q[BC_W-1:2] + WC_W'(|bc_q[1:0]);
    assign xfer       = mem_req && mem_gnt;
    assign ok         = xfer && !mem_err;
    assign acc_n      = (sidx_q == '0) ? mem_rdata : (acc_q ^ mem_rdata);
    assign last_src   = ({1'b0, sidx_q} == (nsrc - 1'b1));
    assign last_word  = ((widx_q + WC_W'(1)) == nwords);
    assign last_fetch = (step_q == (6'd4 + 6'(ctl_q.nsrc_m1)));
    assign post_st    = ctl_q.wback ? ST_WB : ST_DONE;
    assign first_st   = (nwords == '0) ? post_st :
                        ((ctl_q.fill && !ctl_q.zchk) ? ST_WR : ST_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            ctl_q   <= '0;
            step_q  <= '0;
            sidx_q  <= '0;
            widx_q  <= '0;
            zr_q    <= 1'b0;
            acc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_q   <= start_addr;
                        step_q  <= '0;
                        state_q <= ST_FETCH;
                    end else if (append && cur_q != '0) begin
                        state_q <= ST_LINK;
                    end
                end
                ST_FETCH: if (ok) begin
                    case (step_q)
                        6'd0: begin
                            ctl_q.irq_en  <= mem_rdata[0];
                            ctl_q.nsrc_m1 <= mem_rdata[6:3];
                            ctl_q.zchk    <= mem_rdata[7];
                            ctl_q.fill    <= mem_rdata[8];
                            ctl_q.wback   <= mem_rdata[11];
                        end
                        6'd1:    fill_q <= mem_rdata;
                        6'd2:    bc_q   <= mem_rdata[BC_W-1:0];
                        6'd3:    dest_q <= mem_rdata;
                        default: src_q[IW'(step_q - 6'd4)] <= mem_rdata;
                    endcase
                    if (step_q > 6'd3 && last_fetch) begin
                        widx_q  <= '0;
                        sidx_q  <= '0;
                        zr_q    <= 1'b0;
                        state_q <= first_st;
                    end else begin
                        step_q <= step_q + 6'd1;
                    end
                end
                ST_RD: if (ok) begin
                    acc_q <= acc_n;
                    if (last_src) begin
                        sidx_q <= '0;
                        if (ctl_q.zchk) begin
                            zr_q <= zr_q || (acc_n != '0);
                            if (last_word) state_q <= post_st;
                            else           widx_q  <= widx_q + WC_W'(1);
                        end else begin
                            state_q <= ST_WR;
                        end
                    end else begin
                        sidx_q <= sidx_q + IW'(1);
                    end
                end
                ST_WR: if (ok) begin
                    if (last_word) begin
                        state_q <= post_st;
                    end else begin
                        widx_q  <= widx_q + WC_W'(1);
                        state_q <= ctl_q.fill ? ST_WR : ST_RD;
                    end
                end
                ST_WB:   if (ok) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_LINK;
                ST_LINK: if (ok) begin
                    if (mem_rdata != '0) begin
                        cur_q   <= mem_rdata;
                        step_q  <= '0;
                        state_q <= ST_FETCH;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (xfer && mem_err) state_q <= ST_IDLE;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = (step_q < 6'd4) ?
                           cur_q + ADDR_W'({step_q, 2'b00}) + ADDR_W'(4) :
                           cur_q + ADDR_W'({step_q, 3'b000}) - ADDR_W'(8);
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_q[sidx_q] + ADDR_W'({widx_q, 2'b00});
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dest_q + ADDR_W'({widx_q, 2'b00});
                mem_wdata = ctl_q.fill ? fill_q : acc_q;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + ADDR_W'(12);
                mem_wdata = {1'b1, zr_q, 6'b0, bc_q};
            end
            ST_LINK: begin
                mem_req  = 1'b1;
                mem_addr = cur_q;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign cur_desc = cur_q;
    assign set_eot  = (state_q == ST_DONE);
    assign arm_irq  = (state_q == ST_DONE) && ctl_q.irq_en;
    assign set_eoc  = (state_q == ST_LINK) && ok && (mem_rdata == '0);
    assign set_err  = xfer && mem_err;

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_src_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD) |-> ({1'b0, sidx_q} < nsrc));

    assert_zchk_no_data_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && ctl_q.zchk) |-> (mem_addr == cur_q + ADDR_W'(12)));

    assert_err_holds_cur_R9: assert property (@(posedge clk) disable iff (rst)
        set_err |=> ($stable(cur_q) && !busy));
endmodule

// File: rtl/xdma_engine.sv
module xdma_engine
    import xdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err
);
    logic              busy, start, append;
    logic              set_eot, set_eoc, set_err, arm_irq;
    logic [ADDR_W-1:0] cur_desc, start_addr;

    xdma_regs regs_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .cur_desc(cur_desc),
        .set_eot(set_eot), .set_eoc(set_eoc), .set_err(set_err), .arm_irq(arm_irq),
        .start(start), .append(append), .start_addr(start_addr), .irq(irq)
    );

    xdma_core core_i (
        .clk(clk), .rst(rst),
        .start(start), .append(append), .start_addr(start_addr),
        .busy(busy), .cur_desc(cur_desc),
        .set_eot(set_eot), .set_eoc(set_eoc), .set_err(set_err), .arm_irq(arm_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
endmodule

// File: tb/xdma_engine_tb.sv
module xdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = 6'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:4095];
    logic        tb_we = 1'b0;
    logic [11:0] tb_a = '0;
    logic [31:0] tb_d = '0;
    logic [2:0]  gph;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    xdma_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    assign mem_err   = |mem_addr[31:14];
    assign mem_gnt   = mem_req && (gph != 3'd2) && (gph != 3'd5);
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (rst) begin
            gph <= '0;
            for (int i = 0; i < 4096; i++) mem[i] <= '0;
        end else begin
            gph <= gph + 3'd1;
            if (tb_we) mem[tb_a] <= tb_d;
            else if (mem_req && mem_gnt && mem_we && !mem_err) mem[mem_addr[13:2]] <= mem_wdata;
        end
    end

    task automatic chk(input bit cond, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic mw(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a[13:2]; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic rw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rr(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] link, input logic [31:0] ctl,
                            input logic [31:0] fill, input logic [31:0] bc, input logic [31:0] dst);
        mw(b, link); mw(b + 4, ctl); mw(b + 8, fill); mw(b + 12, bc);
        mw(b + 16, dst); mw(b + 20, 32'hFFFF_FFFF);
    endtask

    task automatic put_src(input logic [31:0] b, input int i, input logic [31:0] a);
        mw(b + 24 + 8 * i, a);
        mw(b + 28 + 8 * i, 32'hFFFF_FFFF);
    endtask

    task automatic clean();
        rw(6'h00, 32'h0);
        rw(6'h04, 32'h0000_1808);
    endtask

    task automatic run(input logic [31:0] first);
        logic [31:0] s;
        rw(6'h24, first);
        rw(6'h00, 32'h1);
        for (int n = 0; n < 5000; n++) begin
            rr(6'h04, s);
            if (!s[13]) break;
        end
    endtask

    function automatic logic [31:0] pat(input int s, input int w);
        return 32'h9E37_79B9 * (s * 4 + w + 1) ^ (32'h1 << s);
    endfunction

    task automatic t_reset();
        logic [31:0] s;
        rr(6'h04, s);
        chk(s == 32'h0, "R1 status after reset", s, 32'h0);
        chk(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        chk(mem_req == 1'b0, "R1 no request after reset", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_copy();
        logic [31:0] s;
        clean();
        put_desc(32'h100, 32'h0, 32'h6, 32'h0, 32'd16, 32'h2000);
        put_src(32'h100, 0, 32'h1400);
        for (int i = 0; i < 4; i++) mw(32'h1400 + 4 * i, 32'hC0DE_0000 + i);
        run(32'h100);
        for (int i = 0; i < 4; i++)
            chk(mem[(32'h2000 >> 2) + i] == 32'hC0DE_0000 + i, "R2 copy word",
                mem[(32'h2000 >> 2) + i], 32'hC0DE_0000 + i);
        rr(6'h04, s);
        chk(s == 32'h0000_1800, "R7 eot and eoc set, busy low", s, 32'h0000_1800);
        rr(6'h08, s);
        chk(s == 32'h100, "R11 current descriptor", s, 32'h100);
        chk(irq == 1'b0, "R10 no irq without enable", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_xor16();
        logic [31:0] e;
        clean();
        put_desc(32'h800, 32'h0, 32'h6 | (32'd15 << 3), 32'h0, 32'd8, 32'h2040);
        for (int s = 0; s < 16; s++) begin
            put_src(32'h800, s, 32'h1000 + 32'h10 * s);
            mw(32'h1000 + 32'h10 * s, pat(s, 0));
            mw(32'h1004 + 32'h10 * s, pat(s, 1));
        end
        run(32'h800);
        for (int w = 0; w < 2; w++) begin
            e = '0;
            for (int s = 0; s < 16; s++) e ^= pat(s, w);
            chk(mem[(32'h2040 >> 2) + w] == e, "R3 xor of 16 sources",
                mem[(32'h2040 >> 2) + w], e);
        end
    endtask

    task automatic t_fill();
        clean();
        mw(32'h210C, 32'h5EE7_1E55);
        put_desc(32'h180, 32'h0, 32'h106, 32'hA5A5_5A5A, 32'd12, 32'h2100);
        put_src(32'h180, 0, 32'h1400);
        run(32'h180);
        for (int i = 0; i < 3; i++)
            chk(mem[(32'h2100 >> 2) + i] == 32'hA5A5_5A5A, "R4 fill word",
                mem[(32'h2100 >> 2) + i], 32'hA5A5_5A5A);
        chk(mem[32'h210C >> 2] == 32'h5EE7_1E55, "R4 word past buffer untouched",
            mem[32'h210C >> 2], 32'h5EE7_1E55);
    endtask

    task automatic t_zero_check();
        logic [31:0] s;
        clean();
        mw(32'h2200, 32'h5EE7_1E55);
        put_desc(32'h300, 32'h340, 32'h886 | (32'd1 << 3), 32'h0, 32'd8, 32'h2200);
        put_src(32'h300, 0, 32'h1500);
        put_src(32'h300, 1, 32'h1510);
        put_desc(32'h340, 32'h0, 32'h886 | (32'd1 << 3), 32'h0, 32'd8, 32'h2200);
        put_src(32'h340, 0, 32'h1500);
        put_src(32'h340, 1, 32'h1520);
        mw(32'h1500, 32'h1234_5678); mw(32'h1504, 32'h0BAD_F00D);
        mw(32'h1510, 32'h1234_5678); mw(32'h1514, 32'h0BAD_F00D);
        mw(32'h1520, 32'h1234_5678); mw(32'h1524, 32'h0BAD_F00C);
        run(32'h300);
        chk(mem[32'h30C >> 2] == 32'h8000_0008, "R5 clean parity write-back",
            mem[32'h30C >> 2], 32'h8000_0008);
        chk(mem[32'h34C >> 2] == 32'hC000_0008, "R5 bad parity write-back",
            mem[32'h34C >> 2], 32'hC000_0008);
        chk(mem[32'h2200 >> 2] == 32'h5EE7_1E55, "R5 no destination write",
            mem[32'h2200 >> 2], 32'h5EE7_1E55);
        rr(6'h08, s);
        chk(s == 32'h340, "R7 chain followed to second descriptor", s, 32'h340);
    endtask

    task automatic t_marker();
        logic [31:0] s;
        clean();
        mw(32'h2300, 32'h5EE7_1E55);
        put_desc(32'h400, 32'h0, 32'h7, 32'h0, 32'd0, 32'h2300);
        put_src(32'h400, 0, 32'h1400);
        run(32'h400);
        rr(6'h04, s);
        chk(s == 32'h0000_1800, "R6 marker completes", s, 32'h0000_1800);
        chk(mem[32'h2300 >> 2] == 32'h5EE7_1E55, "R6 marker moves no data",
            mem[32'h2300 >> 2], 32'h5EE7_1E55);
        chk(irq == 1'b1, "R10 irq after enabled completion", {31'b0, irq}, 32'h1);
        rw(6'h04, 32'h0000_1000);
        #1 chk(irq == 1'b1, "R10 irq held by end-of-chain", {31'b0, irq}, 32'h1);
        rw(6'h04, 32'h0000_0800);
        #1 chk(irq == 1'b0, "R10 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_append();
        logic [31:0] s;
        clean();
        put_desc(32'h500, 32'h0, 32'h6, 32'h0, 32'd4, 32'h2400);
        put_src(32'h500, 0, 32'h1600);
        mw(32'h1600, 32'hAAAA_0001);
        put_desc(32'h540, 32'h0, 32'h6, 32'h0, 32'd4, 32'h2410);
        put_src(32'h540, 0, 32'h1610);
        mw(32'h1610, 32'hBBBB_0002);
        run(32'h500);
        rw(6'h04, 32'h0000_1808);
        mw(32'h500, 32'h540);
        rw(6'h00, 32'h3);
        for (int n = 0; n < 2000; n++) begin
            rr(6'h04, s);
            if (!s[13]) break;
        end
        chk(mem[32'h2410 >> 2] == 32'hBBBB_0002, "R8 appended descriptor ran",
            mem[32'h2410 >> 2], 32'hBBBB_0002);
        rr(6'h08, s);
        chk(s == 32'h540, "R8 current descriptor after append", s, 32'h540);
    endtask

    task automatic t_error();
        logic [31:0] s;
        clean();
        put_desc(32'h600, 32'h0, 32'h6, 32'h0, 32'd4, 32'h2500);
        put_src(32'h600, 0, 32'h0002_0000);
        run(32'h600);
        rr(6'h04, s);
        chk(s == 32'h0000_0008, "R9 error flag, busy low", s, 32'h0000_0008);
        rr(6'h00, s);
        chk(s == 32'h0, "R9 enable cleared", s, 32'h0);
        rr(6'h08, s);
        chk(s == 32'h600, "R9 current descriptor kept", s, 32'h600);
        chk(irq == 1'b1, "R10 irq on error", {31'b0, irq}, 32'h1);
        rw(6'h04, 32'h0000_0008);
        #1 chk(irq == 1'b0, "R10 irq cleared after error", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_copy();
        t_xor16();
        t_fill();
        t_zero_check();
        t_marker();
        t_append();
        t_error();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule